// File: doc/BRIEF.md
# Segmented Address Translation Unit

This unit turns a request made of a segment-register index, a 16-bit offset and an access kind into a physical address. It has two modes.

In real mode, the selector held by the chosen segment register is shifted left by four bits and added to the offset. The sum wraps at 20 bits. No checks are made in this mode.

In protected mode, each of the four segment registers has a private descriptor entry. An entry holds a base, a limit and a rights code. It is loaded in the same write that stores the selector. Every access is checked against the entry of the addressed segment, instruction fetches included. An access that passes produces base plus offset, wrapping at 24 bits. An access that fails produces a fault code and no address.

A two-state mode machine sets the operating mode. Its state `MODE_REAL` is entered at reset. Transition `go_prot` moves it to `MODE_PROT` when the mode input is high at a clock edge. Transition `go_real` moves it back to `MODE_REAL` when the mode input is low at a clock edge. Each request is translated under the registered mode. The response is registered and appears one cycle after the request. The descriptor entries cannot be read from the ports; they are visible only through translations.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset the unit is in real mode, all four descriptor entries are invalid, and `rsp_o`, `addr_vld_o`, `paddr_o` and `fault_o` are zero.
- R2: A request sampled at a clock edge gives `rsp_o` = 1 during the following cycle. A cycle with no request gives `rsp_o` = 0 and `addr_vld_o` = 0 in the following cycle.
- R3: In real mode `paddr_o` = ((selector << 4) + offset) mod 2^20, with bits 23:20 equal to zero. In this mode `addr_vld_o` = 1 and `fault_o` = 0 for every access kind.
- R4: A segment write (`sw_en_i`) stores the selector, base, limit and rights code into entry `sw_idx_i` and marks that entry valid. A request in the same cycle as the write sees the entry's previous contents.
- R5: In protected mode, an access that passes every check gives `addr_vld_o` = 1, `fault_o` = 0 and `paddr_o` = (base + offset) mod 2^24.
- R6: An offset greater than the cached limit gives fault code 1 (limit). An offset equal to the limit is allowed.
- R7: The access kinds are 0 = code fetch, 1 = data read, 2 = data write, 3 = reserved. The rights codes are 0 = data read-only, 1 = data read/write, 2 = code execute-only, 3 = code execute/read. A fetch is allowed only with rights code 2 or 3. A read is refused with rights code 2. A write is allowed only with rights code 1. The reserved kind is always refused. A refused access gives fault code 2 (rights).
- R8: In protected mode, an access to an invalid entry gives fault code 3.
- R9: When more than one fault applies, an invalid entry wins over a rights fault, and a rights fault wins over a limit fault.
- R10: On any fault, `addr_vld_o` = 0 and `paddr_o` = 0.
- R11: The mode input takes effect for requests from the cycle after it is sampled. Changing mode keeps every entry's contents.
- R12: A write to one entry leaves the other three entries unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prot_mode_i | input | 1 | 1 selects protected mode, 0 selects real mode |
| sw_en_i | input | 1 | Segment register write strobe |
| sw_idx_i | input | 2 | Segment register written |
| sw_sel_i | input | 16 | Selector value written |
| sw_base_i | input | 24 | Descriptor base loaded with the selector |
| sw_limit_i | input | 16 | Descriptor limit (highest legal offset) |
| sw_rights_i | input | 2 | Descriptor rights code (see R7) |
| req_i | input | 1 | Translation request |
| req_seg_i | input | 2 | Segment register used by the request |
| req_off_i | input | 16 | Offset within the segment |
| req_kind_i | input | 2 | Access kind (see R7) |
| rsp_o | output | 1 | Response present, one cycle after the request |
| addr_vld_o | output | 1 | Translated address is usable |
| paddr_o | output | 24 | Physical address |
| fault_o | output | 2 | 0 none, 1 limit, 2 rights, 3 invalid entry |

## Verification
The hardest case to reach from the ports is a segment write and a request to the same segment landing in the same clock cycle. That request must still see the old descriptor. A dedicated task drives both strobes in one cycle and then issues a second request to confirm that the new contents arrive. A second hard case is a mode switch. Entries must survive a round trip through real mode, and the switch must take effect only from the cycle after the mode input is sampled. The bench reaches this by changing the mode input and re-issuing requests to entries that were already loaded.

// File: rtl/segx_pkg.sv
package segx_pkg;
    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        RT_DATA_RO = 2'd0,
        RT_DATA_RW = 2'd1,
        RT_CODE_XO = 2'd2,
        RT_CODE_XR = 2'd3
    } rights_e;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_LIMIT   = 2'd1,
        FLT_RIGHTS  = 2'd2,
        FLT_INVALID = 2'd3
    } fault_e;

    typedef enum logic {
        MODE_REAL = 1'b0,
        MODE_PROT = 1'b1
    } mode_e;
endpackage

// File: rtl/seg_desc_cache.sv
module seg_desc_cache #(
    parameter int NSEG  = 4,
    parameter int OFF_W = 16,
    parameter int PA_W  = 24,
    localparam int IDX_W = $clog2(NSEG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [OFF_W-1:0] wr_sel,
    input  logic [PA_W-1:0]  wr_base,
    input  logic [OFF_W-1:0] wr_limit,
    input  logic [1:0]       wr_rights,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [OFF_W-1:0] rd_sel,
    output logic [PA_W-1:0]  rd_base,
    output logic [OFF_W-1:0] rd_limit,
    output logic [1:0]       rd_rights
);
    logic [NSEG-1:0]  vld_q;
    logic [OFF_W-1:0] sel_q   [NSEG];
    logic [PA_W-1:0]  base_q  [NSEG];
    logic [OFF_W-1:0] lim_q   [NSEG];
    logic [1:0]       rts_q   [NSEG];

    for (genvar g = 0; g < NSEG; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_q[g]  <= 1'b0;
                sel_q[g]  <= '0;
                base_q[g] <= '0;
                lim_q[g]  <= '0;
                rts_q[g]  <= '0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                vld_q[g]  <= 1'b1;
                sel_q[g]  <= wr_sel;
                base_q[g] <= wr_base;
                lim_q[g]  <= wr_limit;
                rts_q[g]  <= wr_rights;
            end
        end
    end

    assign rd_valid  = vld_q[rd_idx];
    assign rd_sel    = sel_q[rd_idx];
    assign rd_base   = base_q[rd_idx];
    assign rd_limit  = lim_q[rd_idx];
    assign rd_rights = rts_q[rd_idx];

    // R4: a write leaves its entry valid holding the written limit
    p_wr_loads_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (vld_q[$past(wr_idx)] && lim_q[$past(wr_idx)] == $past(wr_limit)));
endmodule

// File: rtl/seg_access_check.sv
module seg_access_check
    import segx_pkg::*;
#(
    parameter int OFF_W = 16
) (
    input  logic             ent_valid,
    input  logic [1:0]       ent_rights,
    input  logic [OFF_W-1:0] ent_limit,
    input  logic [OFF_W-1:0] off,
    input  logic [1:0]       kind,
    output fault_e           fault
);
    logic allowed;

    always_comb begin
        unique case (acc_e'(kind))
            ACC_FETCH: allowed = ent_rights[1];
            ACC_READ:  allowed = (rights_e'(ent_rights) != RT_CODE_XO);
            ACC_WRITE: allowed = (rights_e'(ent_rights) == RT_DATA_RW);
            default:   allowed = 1'b0;
        endcase
    end

    always_comb begin
        if (!ent_valid)            fault = FLT_INVALID;
        else if (!allowed)         fault = FLT_RIGHTS;
        else if (off > ent_limit)  fault = FLT_LIMIT;
        else                       fault = FLT_NONE;
    end
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
    import segx_pkg::*;
#(
    parameter int NSEG  = 4,
    parameter int OFF_W = 16,
    parameter int PA_W  = 24,
    parameter int SHIFT = 4,
    localparam int IDX_W = $clog2(NSEG),
    localparam int RA_W  = OFF_W + SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prot_mode_i,
    input  logic             sw_en_i,
    input  logic [IDX_W-1:0] sw_idx_i,
    input  logic [OFF_W-1:0] sw_sel_i,
    input  logic [PA_W-1:0]  sw_base_i,
    input  logic [OFF_W-1:0] sw_limit_i,
    input  logic [1:0]       sw_rights_i,
    input  logic             req_i,
    input  logic [IDX_W-1:0] req_seg_i,
    input  logic [OFF_W-1:0] req_off_i,
    input  logic [1:0]       req_kind_i,
    output logic             rsp_o,
    output logic             addr_vld_o,
    output logic [PA_W-1:0]  paddr_o,
    output logic [1:0]       fault_o
);
    mode_e mode_q, mode_d;

    logic             e_valid;
    logic [OFF_W-1:0] e_sel;
    logic [PA_W-1:0]  e_base;
    logic [OFF_W-1:0] e_limit;
    logic [1:0]       e_rights;
    fault_e           chk_fault;
    logic [RA_W-1:0]  real_sum;
    logic [PA_W-1:0]  prot_sum;

    seg_desc_cache #(.NSEG(NSEG), .OFF_W(OFF_W), .PA_W(PA_W)) u_cache (
        .clk(clk), .rst_n(rst_n),
        .wr_en(sw_en_i), .wr_idx(sw_idx_i), .wr_sel(sw_sel_i),
        .wr_base(sw_base_i), .wr_limit(sw_limit_i), .wr_rights(sw_rights_i),
        .rd_idx(req_seg_i), .rd_valid(e_valid), .rd_sel(e_sel),
        .rd_base(e_base), .rd_limit(e_limit), .rd_rights(e_rights)
    );

    seg_access_check #(.OFF_W(OFF_W)) u_check (
        .ent_valid(e_valid), .ent_rights(e_rights), .ent_limit(e_limit),
        .off(req_off_i), .kind(req_kind_i), .fault(chk_fault)
    );

    assign real_sum = {e_sel, {SHIFT{1'b0}}} + RA_W'(req_off_i);
    assign prot_sum = e_base + PA_W'(req_off_i);

    // mode machine: next-state logic
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_REAL: if (prot_mode_i)  mode_d = MODE_PROT;  // go_prot
            MODE_PROT: if (!prot_mode_i) mode_d = MODE_REAL;  // go_real
            default:   mode_d = MODE_REAL;
        endcase
    end

    // mode machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_REAL;
        else        mode_q <= mode_d;
    end

    // outputs: registered response
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_o      <= 1'b0;
            addr_vld_o <= 1'b0;
            paddr_o    <= '0;
            fault_o    <= FLT_NONE;
        end else begin
            rsp_o      <= req_i;
            addr_vld_o <= 1'b0;
            paddr_o    <= '0;
            fault_o    <= FLT_NONE;
            if (req_i) begin
                unique case (mode_q)
                    MODE_REAL: begin
                        addr_vld_o <= 1'b1;
                        paddr_o    <= PA_W'(real_sum);
                    end
                    MODE_PROT: begin
                        fault_o <= chk_fault;
                        if (chk_fault == FLT_NONE) begin
                            addr_vld_o <= 1'b1;
                            paddr_o    <= prot_sum;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R2: response follows request by one cycle
    p_resp_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> rsp_o);
    // R2: no request gives a quiet response next cycle
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> (!rsp_o && !addr_vld_o));
    // R3: real mode never faults and stays within 20 bits
    p_real_nofault_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && mode_q == MODE_REAL) |=>
            (fault_o == FLT_NONE && addr_vld_o && paddr_o[PA_W-1:RA_W] == '0));
    // R10: a fault blocks the address
    p_fault_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o != FLT_NONE) |-> (!addr_vld_o && paddr_o == '0));
endmodule

// File: tb/seg_xlate_unit_tb.sv
`timescale 1ns/1ps
module seg_xlate_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prot_mode_i = 1'b0;
    logic        sw_en_i = 1'b0;
    logic [1:0]  sw_idx_i = '0;
    logic [15:0] sw_sel_i = '0;
    logic [23:0] sw_base_i = '0;
    logic [15:0] sw_limit_i = '0;
    logic [1:0]  sw_rights_i = '0;
    logic        req_i = 1'b0;
    logic [1:0]  req_seg_i = '0;
    logic [15:0] req_off_i = '0;
    logic [1:0]  req_kind_i = '0;
    logic        rsp_o, addr_vld_o;
    logic [23:0] paddr_o;
    logic [1:0]  fault_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    seg_xlate_unit u_dut (
        .clk(clk), .rst_n(rst_n), .prot_mode_i(prot_mode_i),
        .sw_en_i(sw_en_i), .sw_idx_i(sw_idx_i), .sw_sel_i(sw_sel_i),
        .sw_base_i(sw_base_i), .sw_limit_i(sw_limit_i), .sw_rights_i(sw_rights_i),
        .req_i(req_i), .req_seg_i(req_seg_i), .req_off_i(req_off_i),
        .req_kind_i(req_kind_i), .rsp_o(rsp_o), .addr_vld_o(addr_vld_o),
        .paddr_o(paddr_o), .fault_o(fault_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic seg_write(input logic [1:0] idx, input logic [15:0] sel,
                             input logic [23:0] base, input logic [15:0] lim,
                             input logic [1:0] rts);
        @(negedge clk);
        sw_en_i = 1'b1; sw_idx_i = idx; sw_sel_i = sel;
        sw_base_i = base; sw_limit_i = lim; sw_rights_i = rts;
        @(negedge clk);
        sw_en_i = 1'b0;
    endtask

    task automatic set_mode(input logic prot);
        @(negedge clk);
        prot_mode_i = prot;
        @(negedge clk);
    endtask

    // issue one request, then compare the response seen one cycle later
    task automatic xlate(input string tag, input logic [1:0] seg, input logic [15:0] off,
                         input logic [1:0] kind, input logic vld, input logic [23:0] pa,
                         input logic [1:0] flt);
        @(negedge clk);
        req_i = 1'b1; req_seg_i = seg; req_off_i = off; req_kind_i = kind;
        @(negedge clk);
        req_i = 1'b0;
        check({tag, " rsp"},   {31'd0, rsp_o}, 32'd1);
        check({tag, " vld"},   {31'd0, addr_vld_o}, {31'd0, vld});
        check({tag, " paddr"}, {8'd0, paddr_o}, {8'd0, pa});
        check({tag, " fault"}, {30'd0, fault_o}, {30'd0, flt});
    endtask

    task automatic t_reset;
        check("R1 rsp at reset",   {31'd0, rsp_o}, 32'd0);
        check("R1 vld at reset",   {31'd0, addr_vld_o}, 32'd0);
        check("R1 paddr at reset", {8'd0, paddr_o}, 32'd0);
        check("R1 fault at reset", {30'd0, fault_o}, 32'd0);
        // R1: real mode at reset, selector zero
        xlate("R1 real after reset", 2'd0, 16'h0042, 2'd1, 1'b1, 24'h000042, 2'd0);
        set_mode(1'b1);
        xlate("R1 R8 entry invalid", 2'd0, 16'h0000, 2'd1, 1'b0, 24'h0, 2'd3);
        xlate("R9 invalid beats rights", 2'd1, 16'hFFFF, 2'd3, 1'b0, 24'h0, 2'd3);
        set_mode(1'b0);
    endtask

    task automatic t_latency;
        @(negedge clk);
        req_i = 1'b1; req_seg_i = 2'd0; req_off_i = 16'h0001; req_kind_i = 2'd0;
        @(negedge clk);
        req_i = 1'b0;
        check("R2 rsp after req", {31'd0, rsp_o}, 32'd1);
        @(negedge clk);
        check("R2 rsp idle", {31'd0, rsp_o}, 32'd0);
        check("R2 vld idle", {31'd0, addr_vld_o}, 32'd0);
    endtask

    task automatic t_real;
        seg_write(2'd1, 16'h1234, 24'hABCDEF, 16'h0000, 2'd0);
        xlate("R3 real sum", 2'd1, 16'h0010, 2'd2, 1'b1, 24'h012350, 2'd0);
        seg_write(2'd1, 16'hFFFF, 24'h0, 16'h0, 2'd0);
        xlate("R3 real wrap", 2'd1, 16'hFFFF, 2'd3, 1'b1, 24'h0FFEF, 2'd0);
    endtask

    task automatic t_prot;
        seg_write(2'd2, 16'h0100, 24'h123400, 16'h0FFF, 2'd1);
        set_mode(1'b1);
        xlate("R5 R6 at limit", 2'd2, 16'h0FFF, 2'd2, 1'b1, 24'h1243FF, 2'd0);
        xlate("R6 R10 past limit", 2'd2, 16'h1000, 2'd1, 1'b0, 24'h0, 2'd1);
        seg_write(2'd0, 16'h0000, 24'hFFFFF0, 16'hFFFF, 2'd1);
        xlate("R5 base wrap", 2'd0, 16'h0020, 2'd1, 1'b1, 24'h000010, 2'd0);
    endtask

    task automatic t_rights;
        seg_write(2'd1, 16'h0, 24'h010000, 16'h00FF, 2'd0);
        xlate("R7 write to RO", 2'd1, 16'h0004, 2'd2, 1'b0, 24'h0, 2'd2);
        xlate("R7 read RO", 2'd1, 16'h0004, 2'd1, 1'b1, 24'h010004, 2'd0);
        xlate("R7 fetch data", 2'd1, 16'h0004, 2'd0, 1'b0, 24'h0, 2'd2);
        xlate("R9 rights beats limit", 2'd1, 16'h0400, 2'd2, 1'b0, 24'h0, 2'd2);
        seg_write(2'd1, 16'h0, 24'h020000, 16'h00FF, 2'd2);
        xlate("R7 read XO", 2'd1, 16'h0008, 2'd1, 1'b0, 24'h0, 2'd2);
        xlate("R7 fetch XO", 2'd1, 16'h0008, 2'd0, 1'b1, 24'h020008, 2'd0);
        xlate("R7 reserved kind", 2'd1, 16'h0008, 2'd3, 1'b0, 24'h0, 2'd2);
        seg_write(2'd1, 16'h0, 24'h030000, 16'h00FF, 2'd3);
        xlate("R7 read XR", 2'd1, 16'h0010, 2'd1, 1'b1, 24'h030010, 2'd0);
        xlate("R7 write XR", 2'd1, 16'h0010, 2'd2, 1'b0, 24'h0, 2'd2);
        xlate("R9 limit only", 2'd1, 16'h0100, 2'd0, 1'b0, 24'h0, 2'd1);
    endtask

    task automatic t_same_cycle;
        seg_write(2'd3, 16'h0, 24'h400000, 16'hFFFF, 2'd1);
        @(negedge clk);
        sw_en_i = 1'b1; sw_idx_i = 2'd3; sw_sel_i = 16'h0;
        sw_base_i = 24'h500000; sw_limit_i = 16'h000F; sw_rights_i = 2'd0;
        req_i = 1'b1; req_seg_i = 2'd3; req_off_i = 16'h0100; req_kind_i = 2'd2;
        @(negedge clk);
        sw_en_i = 1'b0; req_i = 1'b0;
        check("R4 old vld", {31'd0, addr_vld_o}, 32'd1);
        check("R4 old paddr", {8'd0, paddr_o}, 32'h00400100);
        xlate("R4 new descriptor", 2'd3, 16'h0100, 2'd2, 1'b0, 24'h0, 2'd2);
        xlate("R12 seg2 intact", 2'd2, 16'h0001, 2'd1, 1'b1, 24'h123401, 2'd0);
    endtask

    task automatic t_mode;
        @(negedge clk);
        prot_mode_i = 1'b0;
        req_i = 1'b1; req_seg_i = 2'd2; req_off_i = 16'h0002; req_kind_i = 2'd1;
        @(negedge clk);
        req_i = 1'b0;
        check("R11 switch not yet", {8'd0, paddr_o}, 32'h00123402);
        xlate("R11 real uses selector", 2'd2, 16'h0002, 2'd1, 1'b1, 24'h001002, 2'd0);
        set_mode(1'b1);
        xlate("R11 entry kept", 2'd2, 16'h0003, 2'd1, 1'b1, 24'h123403, 2'd0);
    endtask

    initial begin
        #(5.0 * 200000);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latency();
        t_real();
        t_prot();
        t_rights();
        t_same_cycle();
        t_mode();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule